// File: doc/BRIEF.md
# Delay-Line Calibration Sequencer

This block owns the control word for a bank of programmable delay lines that set the capture timing of a double-data-rate memory interface. Software writes a 32-bit word through a simple write port and reads status back through a read port that always shows the current control state. Three ways of refreshing the lines are supported. A manual recalibration walks every line through an external calibration engine and holds a busy flag until the walk ends. A manual apply step copies software-supplied actual-delay values into every line at once. A periodic automatic mode repeats the walk on a programmable interval and can then copy the fresh results into the actual delays.

The calibration engine is outside the block. For each line in turn the sequencer raises that line's request bit and waits for a done strobe that comes with the computed value. It then stores the value in the line's calibrated-delay register. The delay arithmetic and the analog lines are not modelled. The block only sequences, stores and distributes the values.

Top module: `dlcal_ctrl`

## Requirements
- R1: After reset the read port returns 0, no request bit is raised, and every calibrated-delay and actual-delay register holds 0.
- R2: A write with bit 7 set starts a manual recalibration, provided bit 5 is clear both in the stored word and in the written word. The read port shows bit 7 as 1 from the cycle after the write until the walk ends, and then shows 0.
- R3: A walk raises request bit i (one-hot) for lines 0, 1, ... N-1 in ascending order. Each request holds until a done strobe arrives, and at that strobe the line's calibrated-delay register takes the engine result.
- R4: A manual recalibration leaves the actual-delay registers unchanged.
- R5: A bit 7 write that arrives while a recalibration is busy is ignored. The running walk is not restarted and issues exactly N requests.
- R6: A write with bit 6 set loads every actual-delay register from the software actual-delay input, and the values are visible in the cycle after the write. Bit 6 always reads 0.
- R7: Bit 5 is stored on every write and reads back. With period field P, the counter spans P+1 clocks, so the first request of an automatic walk is visible P+1 clock edges after the edge that stores bit 5.
- R8: At the end of an automatic walk, every actual-delay register takes its line's new calibrated value, unless the inhibit input is high. When the inhibit input is high, the actual delays stay unchanged.
- R9: A write with bit 5 set, or any write while the stored bit 5 is 1, ignores bits 7 and 6.
- R10: Clearing bit 5 shows in the read port in the next cycle. A walk that is already running, or that fell due during it, still completes and updates the calibrated values. After that, no further walk starts.
- R11: Bits 31..8 and 4..0 are ignored on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control-word write strobe |
| cfg_wdata | input | 32 | Control-word write data |
| cfg_rdata | output | 32 | Control-word read data |
| auto_period | input | PERIOD_W | Automatic-walk interval field (P gives P+1 clocks) |
| act_inhibit | input | 1 | Blocks the copy of calibrated values into the actual delays after an automatic walk |
| act_wr_dly | input | LINES*DLY_W | Software actual-delay values, line i at bits i*DLY_W |
| cal_req | output | LINES | One-hot request to the calibration engine |
| cal_done | input | 1 | Engine done strobe for the current request |
| cal_result | input | DLY_W | Engine result that accompanies cal_done |
| cal_dly | output | LINES*DLY_W | Calibrated-delay registers, line i at bits i*DLY_W |
| act_dly | output | LINES*DLY_W | Actual-delay registers, line i at bits i*DLY_W |

## Verification
On every cycle the assertions check the following:
- At most one request bit is raised.
- A walk starts only from idle and goes idle after its last line.
- The busy flag clears only at the end of a manual walk, and a locked write never raises it.
- An apply loads the software values.
- The period counter reloads after every expiry.
- A manual start never coincides with an automatic one.

Other behaviour shows only in the bench's scenarios:
- The line order and the stored results.
- The exact latency of the first automatic request, swept over several period values.
- The lingering pass after auto mode is cleared.
- That no later pass follows it.

// File: rtl/dlcal_pkg.sv
package dlcal_pkg;
  // Control-word bit positions; software decodes these.
  localparam int RECAL_BIT = 7;
  localparam int APPLY_BIT = 6;
  localparam int AUTO_BIT  = 5;

  typedef enum logic {PASS_MANUAL = 1'b0, PASS_AUTO = 1'b1} pass_kind_e;

  // Read-back image: only busy and auto are visible, everything else zero.
  function automatic logic [31:0] ctrl_word(input logic busy, input logic auto_on);
    logic [31:0] w;
    w = '0;
    w[RECAL_BIT] = busy;
    w[AUTO_BIT]  = auto_on;
    return w;
  endfunction

  // Manual controls are locked while auto is stored or being written.
  function automatic logic manual_unlocked(input logic stored_auto, input logic new_auto);
    return !(stored_auto || new_auto);
  endfunction
endpackage

// File: rtl/dlcal_regs.sv
module dlcal_regs
  import dlcal_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  input  logic        seq_hold,
  input  logic        manual_done,
  output logic        auto_en,
  output logic        recal_go,
  output logic        apply_go,
  output logic [31:0] cfg_rdata
);
  logic auto_en_q;
  logic recal_busy_q;
  logic unlocked;
  logic unused_rsvd;

  assign unused_rsvd = ^{cfg_wdata[31:8], cfg_wdata[4:0]};
  assign unlocked = manual_unlocked(auto_en_q, cfg_wdata[AUTO_BIT]);
  assign recal_go = cfg_wr && cfg_wdata[RECAL_BIT] && unlocked && !recal_busy_q && !seq_hold;
  assign apply_go = cfg_wr && cfg_wdata[APPLY_BIT] && unlocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_en_q    <= 1'b0;
      recal_busy_q <= 1'b0;
    end else begin
      if (cfg_wr) auto_en_q <= cfg_wdata[AUTO_BIT];
      if (recal_go)         recal_busy_q <= 1'b1;
      else if (manual_done) recal_busy_q <= 1'b0;
    end
  end

  assign auto_en   = auto_en_q;
  assign cfg_rdata = ctrl_word(recal_busy_q, auto_en_q);

  // R2
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(recal_busy_q) |-> $past(manual_done));
  // R9
  lock_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && auto_en_q) |=> !$rose(recal_busy_q));
endmodule

// File: rtl/dlcal_timer.sv
module dlcal_timer #(
  parameter int PERIOD_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                auto_en,
  input  logic [PERIOD_W-1:0] auto_period,
  input  logic                seq_active,
  output logic                auto_start,
  output logic                auto_pending
);
  logic [PERIOD_W-1:0] cnt_q;
  logic                pend_q;
  logic                auto_due;

  // Preload while off, reload on expiry, otherwise count down.
  function automatic logic [PERIOD_W-1:0] next_count(
    input logic en, input logic [PERIOD_W-1:0] cur, input logic [PERIOD_W-1:0] per);
    if (!en || cur == '0) return per;
    return cur - 1'b1;
  endfunction

  assign auto_due     = auto_en && (cnt_q == '0);
  assign auto_start   = (auto_due || pend_q) && !seq_active;
  assign auto_pending = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= next_count(auto_en, cnt_q, auto_period);
      if (auto_start)    pend_q <= 1'b0;
      else if (auto_due) pend_q <= 1'b1;
    end
  end

  // R7
  period_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_due |=> (cnt_q == $past(auto_period)));
endmodule

// File: rtl/dlcal_seq.sv
module dlcal_seq
  import dlcal_pkg::*;
#(
  parameter int LINES = 18,
  parameter int DLY_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_manual,
  input  logic                   start_auto,
  input  logic                   apply_go,
  input  logic                   act_inhibit,
  input  logic [LINES*DLY_W-1:0] act_wr_dly,
  input  logic                   cal_done,
  input  logic [DLY_W-1:0]       cal_result,
  output logic [LINES-1:0]       cal_req,
  output logic [LINES*DLY_W-1:0] cal_dly,
  output logic [LINES*DLY_W-1:0] act_dly,
  output logic                   seq_active,
  output logic                   manual_done
);
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [LW-1:0] LAST = LW'(LINES - 1);

  logic [LW-1:0] line_q;
  logic          active_q;
  pass_kind_e    kind_q;
  logic          step, pass_end, auto_end;

  assign step        = active_q && cal_done;
  assign pass_end    = step && (line_q == LAST);
  assign auto_end    = pass_end && (kind_q == PASS_AUTO);
  assign manual_done = pass_end && (kind_q == PASS_MANUAL);
  assign seq_active  = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      line_q   <= '0;
      kind_q   <= PASS_MANUAL;
    end else if (start_manual || start_auto) begin
      active_q <= 1'b1;
      line_q   <= '0;
      kind_q   <= start_auto ? PASS_AUTO : PASS_MANUAL;
    end else if (step) begin
      if (pass_end) active_q <= 1'b0;
      else          line_q   <= line_q + 1'b1;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam bit IS_LAST = (i == LINES - 1);
    logic [DLY_W-1:0] cal_r;
    logic [DLY_W-1:0] act_r;
    logic             hit;

    assign hit        = active_q && (line_q == LW'(i));
    assign cal_req[i] = hit;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cal_r <= '0;
        act_r <= '0;
      end else begin
        if (hit && cal_done) cal_r <= cal_result;
        if (apply_go)
          act_r <= act_wr_dly[i*DLY_W +: DLY_W];
        else if (auto_end && !act_inhibit)
          act_r <= IS_LAST ? cal_result : cal_r;
      end
    end

    assign cal_dly[i*DLY_W +: DLY_W] = cal_r;
    assign act_dly[i*DLY_W +: DLY_W] = act_r;
  end

  // R3
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cal_req));
  // R3
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_manual || start_auto) |-> !active_q);
  // R3
  pass_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end |=> !seq_active);
  // R6
  apply_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply_go |=> (act_dly == $past(act_wr_dly)));
endmodule

// File: rtl/dlcal_ctrl.sv
module dlcal_ctrl #(
  parameter int LINES    = 18,
  parameter int DLY_W    = 8,
  parameter int PERIOD_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  input  logic [PERIOD_W-1:0]    auto_period,
  input  logic                   act_inhibit,
  input  logic [LINES*DLY_W-1:0] act_wr_dly,
  output logic [LINES-1:0]       cal_req,
  input  logic                   cal_done,
  input  logic [DLY_W-1:0]       cal_result,
  output logic [LINES*DLY_W-1:0] cal_dly,
  output logic [LINES*DLY_W-1:0] act_dly
);
  logic auto_en, recal_go, apply_go;
  logic auto_start, auto_pending;
  logic seq_active, manual_done;

  dlcal_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_wdata   (cfg_wdata),
    .seq_hold    (seq_active || auto_pending),
    .manual_done (manual_done),
    .auto_en     (auto_en),
    .recal_go    (recal_go),
    .apply_go    (apply_go),
    .cfg_rdata   (cfg_rdata)
  );

  dlcal_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .auto_en      (auto_en),
    .auto_period  (auto_period),
    .seq_active   (seq_active),
    .auto_start   (auto_start),
    .auto_pending (auto_pending)
  );

  dlcal_seq #(.LINES(LINES), .DLY_W(DLY_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_manual (recal_go),
    .start_auto   (auto_start),
    .apply_go     (apply_go),
    .act_inhibit  (act_inhibit),
    .act_wr_dly   (act_wr_dly),
    .cal_done     (cal_done),
    .cal_result   (cal_result),
    .cal_req      (cal_req),
    .cal_dly      (cal_dly),
    .act_dly      (act_dly),
    .seq_active   (seq_active),
    .manual_done  (manual_done)
  );

  // R10
  no_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(recal_go && auto_start));
endmodule

// File: tb/dlcal_ctrl_bench.sv
module dlcal_ctrl_bench;
  localparam int N  = 18;
  localparam int DW = 8;
  localparam int PW = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_wr = 1'b0;
  logic [31:0]     cfg_wdata = '0;
  logic [31:0]     cfg_rdata;
  logic [PW-1:0]   auto_period = '0;
  logic            act_inhibit = 1'b0;
  logic [N*DW-1:0] act_wr_dly = '0;
  logic [N-1:0]    cal_req;
  logic            cal_done = 1'b0;
  logic [DW-1:0]   cal_result = '0;
  logic [N*DW-1:0] cal_dly;
  logic [N*DW-1:0] act_dly;

  int checks = 0;
  int errors = 0;
  int req_count = 0;
  int exp_line = 0;
  logic [7:0] salt = 8'h10;
  logic [7:0] act_exp [N];

  always #10 clk = ~clk;

  dlcal_ctrl u_dlcal_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .auto_period(auto_period), .act_inhibit(act_inhibit),
    .act_wr_dly(act_wr_dly), .cal_req(cal_req), .cal_done(cal_done),
    .cal_result(cal_result), .cal_dly(cal_dly), .act_dly(act_dly)
  );

  function automatic logic [7:0] sw_set(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Engine model: one-hot request, variable latency, result = setting + salt.
  initial begin
    forever begin
      @(negedge clk);
      if (cal_req != '0) begin
        int idx = 0;
        for (int i = 0; i < N; i++) if (cal_req[i]) idx = i;
        chk($countones(cal_req) == 1 && idx == exp_line, "R3 line order", idx, exp_line);
        exp_line = (idx == N - 1) ? 0 : idx + 1;
        repeat (idx % 3) @(negedge clk);
        cal_done   = 1'b1;
        cal_result = sw_set(idx) + salt;
        @(negedge clk);
        cal_done = 1'b0;
        req_count++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 8) begin
      @(negedge clk);
      quiet = (cal_req == '0) ? quiet + 1 : 0;
    end
  endtask

  task automatic check_cal(input string req);
    for (int i = 0; i < N; i++)
      chk(cal_dly[i*DW +: DW] == 8'(sw_set(i) + salt), req, cal_dly[i*DW +: DW], 8'(sw_set(i) + salt));
  endtask

  task automatic check_act(input string req);
    for (int i = 0; i < N; i++)
      chk(act_dly[i*DW +: DW] == act_exp[i], req, act_dly[i*DW +: DW], act_exp[i]);
  endtask

  initial begin
    int rc0;
    int k;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 0, "R1 rdata", cfg_rdata, 0);
    chk(cal_req == 0, "R1 req", cal_req, 0);
    chk(cal_dly == 0, "R1 cal", 0, 0);
    for (int i = 0; i < N; i++) act_exp[i] = 8'h00;
    check_act("R1 act");

    // R2 manual recalibration, R5 retrigger while busy ignored
    salt = 8'h10;
    rc0 = req_count;
    wr(32'h80);
    chk(cfg_rdata == 32'h80, "R2 busy set", cfg_rdata, 32'h80);
    repeat (3) @(negedge clk);
    wr(32'h80);
    chk(cfg_rdata == 32'h80, "R5 still busy", cfg_rdata, 32'h80);
    wait_idle();
    chk(cfg_rdata == 0, "R2 busy clear", cfg_rdata, 0);
    chk(req_count - rc0 == N, "R5 request count", req_count - rc0, N);
    check_cal("R3 stored result");
    check_act("R4 act untouched");

    // R6 apply
    for (int i = 0; i < N; i++) begin
      act_wr_dly[i*DW +: DW] = 8'((i * 11 + 1) & 255);
      act_exp[i] = 8'((i * 11 + 1) & 255);
    end
    wr(32'h40);
    chk(cfg_rdata == 0, "R6 reads zero", cfg_rdata, 0);
    check_act("R6 apply load");

    // R11 reserved bits
    for (int i = 0; i < N; i++) act_wr_dly[i*DW +: DW] = 8'hEE;
    wr(32'hFFFF_FF1F);
    chk(cfg_rdata == 0, "R11 rdata", cfg_rdata, 0);
    rc0 = req_count;
    repeat (20) @(negedge clk);
    chk(cal_req == 0 && req_count == rc0, "R11 no walk", req_count - rc0, 0);
    check_act("R11 act");

    // R7/R8 period sweep
    foreach (act_exp[j]) act_exp[j] = act_exp[j];
    for (int p = 0; p < 20; p += 6) begin
      salt = 8'(8'h20 + p);
      act_inhibit = 1'b0;
      auto_period = PW'(p);
      wr(32'h20);
      chk(cfg_rdata == 32'h20, "R7 auto readback", cfg_rdata, 32'h20);
      k = 1;
      while (cal_req == '0 && k < 2000) begin
        @(negedge clk);
        k++;
      end
      chk(k == p + 2, "R7 first request", k, p + 2);
      wr(32'h00);
      chk(cfg_rdata == 0, "R10 clear at once", cfg_rdata, 0);
      wait_idle();
      check_cal("R8 cal");
      for (int i = 0; i < N; i++) act_exp[i] = 8'(sw_set(i) + salt);
      check_act("R8 copy to act");
    end

    // R9 lockout
    act_inhibit = 1'b1;
    auto_period = PW'(500);
    for (int i = 0; i < N; i++) act_wr_dly[i*DW +: DW] = 8'((i * 5 + 9) & 255);
    wr(32'hE0);
    chk(cfg_rdata == 32'h20, "R9 same-write lock", cfg_rdata, 32'h20);
    check_act("R9 apply locked");
    wr(32'h60);
    check_act("R9 apply ignored");
    wr(32'hA0);
    chk(cfg_rdata == 32'h20, "R9 recal ignored", cfg_rdata, 32'h20);

    // R10 disable mid-pass, R8 inhibit
    salt = 8'h77;
    k = 0;
    while (cal_req == '0 && k < 2000) begin
      @(negedge clk);
      k++;
    end
    wr(32'h00);
    chk(cfg_rdata == 0, "R10 readback", cfg_rdata, 0);
    wait_idle();
    check_cal("R10 lingering pass");
    check_act("R8 inhibit");
    rc0 = req_count;
    repeat (700) @(negedge clk);
    chk(req_count == rc0, "R10 no later pass", req_count - rc0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule